// File: doc/BRIEF.md
# Two-Adapter Interrupt Level Arbiter

This block combines up to 32 device interrupt requests that sit behind two bus adapters. Each request bit belongs to one group: the high group or the low group of adapter 0 or adapter 1. Which bits go to which group is fixed by parameters. Each adapter has a control/status register. That register gives each of its two groups a 3-bit processor priority level, and level 0 turns the group off. The block outputs a mask of the processor levels that have work pending.

When the processor acknowledges a level, the block searches the groups in a fixed order. It takes the lowest-numbered pending request in the first group that matches. One cycle later it returns that request's vector, read from a table written at configuration time, together with the code of the adapter that served it. It also clears the request. The status registers report live pending state when read. A write with the init bit set pulses a reset toward the devices behind that adapter.

Top module: `irq_level_arb`

## Requirements
- R1: After reset the pending requests, the level mask, both status registers, every vector table entry, `dev_reset` and all acknowledge outputs are zero.
- R2: A 1 on `req_set[i]` makes request i pending from the next clock. It stays pending until it is acknowledged. If a set and an acknowledge-clear hit the same bit in the same cycle, the bit stays pending.
- R3: Bit L of `lvl_mask` (L = 1..7) is 1 exactly when some group assigned level L has a pending request. Requests are masked by the parameter maps: adapter 0 high = bits 3:0, low = bits 7:4; adapter 1 high = bits 11:8, low = bits 15:12. Bits 31:16 belong to no group. A group at level 0 contributes nothing, so bit 0 is always 0.
- R4: On an acknowledge at level L, groups are examined in this order: adapter 0 high, adapter 0 low, adapter 1 high, adapter 1 low. The first group whose level equals L (with L nonzero) and that has a pending request wins.
- R5: In the winning group, the lowest-numbered pending bit wins and is cleared. The cycle after `ack_valid`, `ack_done` is 1, `ack_hit` is 1 and `ack_vector` holds the table entry for that bit.
- R6: `ack_adapter` is 2·index+1, so adapter 0 reports 1 and adapter 1 reports 3. If no group matches, `ack_hit`, `ack_vector` and `ack_adapter` are 0 and no request is cleared.
- R7: Status register layout: bits 2:0 are the low-group level, bits 5:3 the high-group level, bit 6 is the transfer-disable flag, bit 7 is the init command, bit 10 is low-pending and bit 11 is high-pending. A read returns the value one cycle after `csr_rd`. It ORs the live group-pending state into bits 11 and 10 and keeps them set afterwards. Bit 7 always reads 0.
- R8: A write with bit 7 clear stores bits 6:0 of `csr_wdata`. It then sets bits 11 and 10 from the live pending state only, which drops any pending flag that was kept from an earlier read.
- R9: A write with bit 7 set keeps only bit 6 of `csr_wdata`, so both levels become 0, and refreshes bits 11 and 10. `dev_reset[sel]` is then 1 for exactly one cycle, the cycle after the write.
- R10: `vt_we` writes `vt_data` into table entry `vt_addr`, and that value is what an acknowledge of that request bit returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 32 | Per-request set pulses |
| req_pend | output | 32 | Pending requests |
| lvl_mask | output | 8 | Processor levels with pending work |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| ack_done | output | 1 | Acknowledge response valid |
| ack_hit | output | 1 | A request was found |
| ack_adapter | output | 2 | Adapter code 1 or 3, 0 on miss |
| ack_vector | output | 16 | Vector of the served request |
| vt_we | input | 1 | Vector table write enable |
| vt_addr | input | 5 | Vector table entry |
| vt_data | input | 16 | Vector table write data |
| csr_rd | input | 1 | Status register read strobe |
| csr_wr | input | 1 | Status register write strobe |
| csr_sel | input | 1 | Adapter selected for register access |
| csr_wdata | input | 12 | Status register write data |
| csr_rdata | output | 12 | Status register read data |
| dev_reset | output | 2 | Per-adapter device reset pulse |

## Verification
A table of request patterns and level assignments is run through the search. One row has a single match, to confirm basic mapping. Other rows put two groups at the same level, once within one adapter and once across the two adapters, which separates the adapter order from the high-before-low order. Further rows use a disabled group whose level is 0, requests on unmapped bits, and a level that only a non-pending group carries; these show that masking comes before matching. Several pending bits in one group show that the lowest index wins. Directed sequences then check that pending flags kept from a read are cleared again by a write, how init writes behave, a set that collides with a clear, and an acknowledge at level 0.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W      = 3;
  localparam int N_LVL      = 1 << LVL_W;
  localparam int CSR_W      = 12;
  localparam int LO_LVL_LSB = 0;
  localparam int HI_LVL_LSB = 3;
  localparam int XDIS_B     = 6;
  localparam int INIT_B     = 7;
  localparam int LO_PEND_B  = 10;
  localparam int HI_PEND_B  = 11;

  localparam logic [CSR_W-1:0] CSR_STORE_MASK = 12'h07F;
  localparam logic [CSR_W-1:0] CSR_INIT_KEEP  = 12'h040;
  localparam logic [CSR_W-1:0] CSR_READ_ZERO  = 12'h080;

  // One-hot of a group level, suppressed for level 0 or an idle group
  function automatic logic [N_LVL-1:0] lvl_onehot(input logic [LVL_W-1:0] lvl,
                                                  input logic any_req);
    lvl_onehot = '0;
    if (any_req && lvl != '0) lvl_onehot[lvl] = 1'b1;
  endfunction

  // Pending-flag overlay for a status register
  function automatic logic [CSR_W-1:0] pend_bits(input logic hi, input logic lo);
    pend_bits = '0;
    pend_bits[HI_PEND_B] = hi;
    pend_bits[LO_PEND_B] = lo;
  endfunction
endpackage

// File: rtl/irq_csr.sv
module irq_csr
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  input  logic             hi_live,
  input  logic             lo_live,
  output logic [CSR_W-1:0] csr_q,
  output logic [CSR_W-1:0] view,
  output logic             init_pulse
);
  logic [CSR_W-1:0] live;
  logic [CSR_W-1:0] wr_val;

  assign live   = pend_bits(hi_live, lo_live);
  assign view   = (csr_q | live) & ~CSR_READ_ZERO;
  assign wr_val = wdata[INIT_B] ? (wdata & CSR_INIT_KEEP) : (wdata & CSR_STORE_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q      <= '0;
      init_pulse <= 1'b0;
    end else begin
      init_pulse <= wr && wdata[INIT_B];
      if (wr)      csr_q <= wr_val | live;
      else if (rd) csr_q <= view;
    end
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int DEPTH = 32,
  parameter int VEC_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [VEC_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [VEC_W-1:0] rdata
);
  logic [DEPTH-1:0][VEC_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n) mem <= '0;
    else if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N_REQ = 32,
  parameter int N_ADP = 2,
  parameter logic [N_ADP*N_REQ-1:0] HI_MAP = '0,
  parameter logic [N_ADP*N_REQ-1:0] LO_MAP = '0,
  localparam int IDX_W = $clog2(N_REQ),
  localparam int AI_W  = (N_ADP > 1) ? $clog2(N_ADP) : 1
) (
  input  logic [N_REQ-1:0]            pend,
  input  logic [N_ADP-1:0][LVL_W-1:0] hi_lvl,
  input  logic [N_ADP-1:0][LVL_W-1:0] lo_lvl,
  input  logic [LVL_W-1:0]            ack_level,
  output logic [N_ADP-1:0]            hi_any,
  output logic [N_ADP-1:0]            lo_any,
  output logic                        hit,
  output logic [AI_W-1:0]             adp,
  output logic [IDX_W-1:0]            idx,
  output logic [N_LVL-1:0]            lvl_mask
);
  logic [N_ADP-1:0][N_REQ-1:0] hi_req;
  logic [N_ADP-1:0][N_REQ-1:0] lo_req;
  logic [N_REQ-1:0]            win_grp;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_REQ-1:0] v);
    lowest_set = '0;
    for (int i = N_REQ - 1; i >= 0; i--)
      if (v[i]) lowest_set = IDX_W'(i);
  endfunction

  for (genvar a = 0; a < N_ADP; a++) begin : g_grp
    assign hi_req[a] = pend & HI_MAP[a*N_REQ +: N_REQ];
    assign lo_req[a] = pend & LO_MAP[a*N_REQ +: N_REQ];
    assign hi_any[a] = |hi_req[a];
    assign lo_any[a] = |lo_req[a];
  end

  always_comb begin
    lvl_mask = '0;
    for (int a = 0; a < N_ADP; a++)
      lvl_mask = lvl_mask | lvl_onehot(hi_lvl[a], hi_any[a])
                          | lvl_onehot(lo_lvl[a], lo_any[a]);
  end

  always_comb begin
    hit     = 1'b0;
    adp     = '0;
    win_grp = '0;
    for (int a = 0; a < N_ADP; a++) begin
      if (!hit && ack_level != '0 && hi_lvl[a] == ack_level && hi_any[a]) begin
        hit = 1'b1; adp = AI_W'(a); win_grp = hi_req[a];
      end
      if (!hit && ack_level != '0 && lo_lvl[a] == ack_level && lo_any[a]) begin
        hit = 1'b1; adp = AI_W'(a); win_grp = lo_req[a];
      end
    end
  end

  assign idx = lowest_set(win_grp);
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter int N_REQ = 32,
  parameter int N_ADP = 2,
  parameter int VEC_W = 16,
  parameter logic [N_ADP*N_REQ-1:0] HI_MAP = 64'h0000_0F00_0000_000F,
  parameter logic [N_ADP*N_REQ-1:0] LO_MAP = 64'h0000_F000_0000_00F0,
  localparam int IDX_W = $clog2(N_REQ),
  localparam int AI_W  = (N_ADP > 1) ? $clog2(N_ADP) : 1,
  localparam int ADP_CW = AI_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_REQ-1:0]   req_set,
  output logic [N_REQ-1:0]   req_pend,
  output logic [N_LVL-1:0]   lvl_mask,
  input  logic               ack_valid,
  input  logic [LVL_W-1:0]   ack_level,
  output logic               ack_done,
  output logic               ack_hit,
  output logic [ADP_CW-1:0]  ack_adapter,
  output logic [VEC_W-1:0]   ack_vector,
  input  logic               vt_we,
  input  logic [IDX_W-1:0]   vt_addr,
  input  logic [VEC_W-1:0]   vt_data,
  input  logic               csr_rd,
  input  logic               csr_wr,
  input  logic [AI_W-1:0]    csr_sel,
  input  logic [CSR_W-1:0]   csr_wdata,
  output logic [CSR_W-1:0]   csr_rdata,
  output logic [N_ADP-1:0]   dev_reset
);
  logic [N_ADP-1:0][CSR_W-1:0] csr_q;
  logic [N_ADP-1:0][CSR_W-1:0] csr_view;
  logic [N_ADP-1:0][LVL_W-1:0] hi_lvl;
  logic [N_ADP-1:0][LVL_W-1:0] lo_lvl;
  logic [N_ADP-1:0]            hi_any;
  logic [N_ADP-1:0]            lo_any;

  // Internal events, named for the checker
  logic                pick_hit;
  logic [AI_W-1:0]     pick_adp;
  logic [IDX_W-1:0]    pick_idx;
  logic                ack_take;
  logic [N_REQ-1:0]    ack_clear;
  logic [VEC_W-1:0]    table_vec;

  for (genvar a = 0; a < N_ADP; a++) begin : g_adp
    assign hi_lvl[a] = csr_q[a][HI_LVL_LSB +: LVL_W];
    assign lo_lvl[a] = csr_q[a][LO_LVL_LSB +: LVL_W];

    irq_csr u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (csr_rd && csr_sel == AI_W'(a)),
      .wr         (csr_wr && csr_sel == AI_W'(a)),
      .wdata      (csr_wdata),
      .hi_live    (hi_any[a]),
      .lo_live    (lo_any[a]),
      .csr_q      (csr_q[a]),
      .view       (csr_view[a]),
      .init_pulse (dev_reset[a])
    );
  end

  irq_pick #(
    .N_REQ (N_REQ), .N_ADP (N_ADP), .HI_MAP (HI_MAP), .LO_MAP (LO_MAP)
  ) u_pick (
    .pend      (req_pend),
    .hi_lvl    (hi_lvl),
    .lo_lvl    (lo_lvl),
    .ack_level (ack_level),
    .hi_any    (hi_any),
    .lo_any    (lo_any),
    .hit       (pick_hit),
    .adp       (pick_adp),
    .idx       (pick_idx),
    .lvl_mask  (lvl_mask)
  );

  irq_vec_table #(.DEPTH (N_REQ), .VEC_W (VEC_W)) u_vt (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (vt_we),
    .waddr (vt_addr),
    .wdata (vt_data),
    .raddr (pick_idx),
    .rdata (table_vec)
  );

  assign ack_take  = ack_valid && pick_hit;
  assign ack_clear = ack_take ? (N_REQ'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_pend    <= '0;
      ack_done    <= 1'b0;
      ack_hit     <= 1'b0;
      ack_adapter <= '0;
      ack_vector  <= '0;
      csr_rdata   <= '0;
    end else begin
      req_pend    <= (req_pend & ~ack_clear) | req_set;
      ack_done    <= ack_valid;
      ack_hit     <= ack_take;
      ack_adapter <= ack_take ? {pick_adp, 1'b1} : '0;
      ack_vector  <= ack_take ? table_vec : '0;
      if (csr_rd) csr_rdata <= csr_view[csr_sel];
    end
  end
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
  parameter int N_REQ = 32,
  parameter int N_ADP = 2,
  parameter int VEC_W = 16,
  localparam int IDX_W = $clog2(N_REQ),
  localparam int AI_W  = (N_ADP > 1) ? $clog2(N_ADP) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] req_set,
  input logic [N_REQ-1:0] req_pend,
  input logic [7:0]       lvl_mask,
  input logic             ack_valid,
  input logic             ack_done,
  input logic             ack_hit,
  input logic [AI_W:0]    ack_adapter,
  input logic [VEC_W-1:0] ack_vector,
  input logic             csr_wr,
  input logic [AI_W-1:0]  csr_sel,
  input logic [11:0]      csr_wdata,
  input logic [N_ADP-1:0] dev_reset,
  input logic             pick_hit,
  input logic [IDX_W-1:0] pick_idx
);
  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_set) |=> ((req_pend & $past(req_set)) == $past(req_set)));

  // R3
  level_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_mask[0]);

  // R5
  winner_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && pick_hit && !req_set[pick_idx]) |=> !req_pend[$past(pick_idx)]);

  // R5
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ack_done);

  // R5
  no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> !ack_done);

  // R6
  odd_adapter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |-> ack_adapter[0]);

  // R6
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && !ack_hit) |-> (ack_vector == '0 && ack_adapter == '0));

  // R9
  init_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_wdata[7]) |=> dev_reset[$past(csr_sel)]);

  // R9
  one_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_reset));
endmodule

bind irq_level_arb irq_level_arb_chk #(.N_REQ(N_REQ), .N_ADP(N_ADP), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_pend(req_pend),
  .lvl_mask(lvl_mask), .ack_valid(ack_valid), .ack_done(ack_done),
  .ack_hit(ack_hit), .ack_adapter(ack_adapter), .ack_vector(ack_vector),
  .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
  .dev_reset(dev_reset), .pick_hit(pick_hit), .pick_idx(pick_idx)
);

// File: tb/sim_irq_level_arb.sv
`timescale 1ns/1ps
module sim_irq_level_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_set = '0;
  logic [31:0] req_pend;
  logic [7:0]  lvl_mask;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_level = '0;
  logic        ack_done, ack_hit;
  logic [1:0]  ack_adapter;
  logic [15:0] ack_vector;
  logic        vt_we = 1'b0;
  logic [4:0]  vt_addr = '0;
  logic [15:0] vt_data = '0;
  logic        csr_rd = 1'b0, csr_wr = 1'b0;
  logic [0:0]  csr_sel = '0;
  logic [11:0] csr_wdata = '0;
  logic [11:0] csr_rdata;
  logic [1:0]  dev_reset;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_level_arb u0 (.*);

  typedef struct packed {
    logic [31:0] pend;
    logic [5:0]  c0;     // {hi, lo} levels adapter 0
    logic [5:0]  c1;     // {hi, lo} levels adapter 1
    logic [2:0]  lvl;
    logic        hit;
    logic [4:0]  idx;
    logic [1:0]  adp;
    logic [7:0]  mask;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{32'h0000_0006, {3'd5,3'd2}, {3'd7,3'd1}, 3'd5, 1'b1, 5'd1,  2'd1, 8'h20},
    '{32'h0000_0C30, {3'd3,3'd4}, {3'd4,3'd6}, 3'd4, 1'b1, 5'd4,  2'd1, 8'h10},
    '{32'h0000_0C30, {3'd3,3'd2}, {3'd4,3'd6}, 3'd4, 1'b1, 5'd10, 2'd3, 8'h14},
    '{32'h0000_8101, {3'd6,3'd6}, {3'd6,3'd6}, 3'd6, 1'b1, 5'd0,  2'd1, 8'h40},
    '{32'h0000_8100, {3'd6,3'd6}, {3'd0,3'd6}, 3'd6, 1'b1, 5'd15, 2'd3, 8'h40},
    '{32'h0001_0000, {3'd7,3'd7}, {3'd7,3'd7}, 3'd7, 1'b0, 5'd0,  2'd0, 8'h00},
    '{32'h0000_0080, {3'd1,3'd3}, {3'd1,3'd1}, 3'd1, 1'b0, 5'd0,  2'd0, 8'h08},
    '{32'h0000_00C8, {3'd2,3'd2}, {3'd5,3'd5}, 3'd2, 1'b1, 5'd3,  2'd1, 8'h04}
  };

  function automatic logic [15:0] vec_of(input int i);
    return 16'hA000 + 16'(i * 3);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_table();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); vt_we = 1'b1; vt_addr = 5'(i); vt_data = vec_of(i);
    end
    @(negedge clk); vt_we = 1'b0;
  endtask

  task automatic csr_write(input logic s, input logic [11:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_sel = s; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic s, output logic [11:0] d);
    @(negedge clk); csr_rd = 1'b1; csr_sel = s;
    @(negedge clk); csr_rd = 1'b0; d = csr_rdata;
  endtask

  task automatic raise(input logic [31:0] v);
    @(negedge clk); req_set = v;
    @(negedge clk); req_set = '0;
  endtask

  task automatic acknowledge(input logic [2:0] l);
    @(negedge clk); ack_valid = 1'b1; ack_level = l;
    @(negedge clk); ack_valid = 1'b0;
  endtask

  initial begin
    logic [11:0] rd;
    // R1: reset state
    do_reset();
    check("R1 pend", req_pend, 0);
    check("R1 mask", lvl_mask, 0);
    check("R1 ack", {ack_done, ack_hit, ack_adapter, ack_vector, dev_reset}, 0);
    csr_read(1'b0, rd); check("R1 csr0", rd, 0);
    acknowledge(3'd1); check("R1 table empty", {ack_hit, ack_vector}, 0);

    // Table walk: R3 R4 R5 R6 R10
    foreach (TBL[k]) begin
      do_reset();
      load_table();
      csr_write(1'b0, {6'd0, TBL[k].c0});
      csr_write(1'b1, {6'd0, TBL[k].c1});
      raise(TBL[k].pend);
      check($sformatf("R2 row%0d pend", k), req_pend, TBL[k].pend);
      check($sformatf("R3 row%0d mask", k), lvl_mask, TBL[k].mask);
      acknowledge(TBL[k].lvl);
      check($sformatf("R4 row%0d hit/adapter", k), {ack_done, ack_hit, ack_adapter},
            {1'b1, TBL[k].hit, TBL[k].adp});
      check($sformatf("R5 R10 row%0d vector", k), ack_vector,
            TBL[k].hit ? vec_of(int'(TBL[k].idx)) : 16'h0);
      check($sformatf("R6 row%0d cleared", k), req_pend,
            TBL[k].hit ? (TBL[k].pend & ~(32'h1 << TBL[k].idx)) : TBL[k].pend);
    end

    // R7 sticky pending on read, R8 refresh on write
    do_reset();
    csr_write(1'b0, 12'h028);
    raise(32'h1);
    csr_read(1'b0, rd); check("R7 read hi pending", rd, 12'h828);
    acknowledge(3'd5);  check("R5 plain ack", {ack_hit, ack_adapter}, 3'b101);
    csr_read(1'b0, rd); check("R7 sticky after clear", rd, 12'h828);
    csr_write(1'b0, 12'h028);
    csr_read(1'b0, rd); check("R8 write drops stale pend", rd, 12'h028);
    raise(32'h10);
    csr_write(1'b0, 12'hF7F);
    csr_read(1'b0, rd); check("R8 stored bits and lo pend", rd, 12'h47F);
    csr_read(1'b1, rd); check("R8 other adapter untouched", rd, 12'h000);

    // R9 init write
    @(negedge clk); csr_wr = 1'b1; csr_sel = 1'b0; csr_wdata = 12'h0ED;
    @(negedge clk); csr_wr = 1'b0;
    check("R9 reset pulse", dev_reset, 2'b01);
    @(negedge clk);
    check("R9 pulse one cycle", dev_reset, 2'b00);
    csr_read(1'b0, rd); check("R9 keep only disable bit", rd, 12'h440);
    check("R9 levels zero mask", lvl_mask, 8'h00);

    // R2 set beats clear, R6 level-0 ack, R10 rewrite
    do_reset();
    load_table();
    csr_write(1'b0, 12'h028);
    raise(32'h1);
    @(negedge clk); ack_valid = 1'b1; ack_level = 3'd5; req_set = 32'h1;
    @(negedge clk); ack_valid = 1'b0; req_set = '0;
    check("R2 served", {ack_hit, ack_vector}, {1'b1, vec_of(0)});
    check("R2 set wins", req_pend, 32'h1);
    acknowledge(3'd0);
    check("R6 level0 miss", {ack_done, ack_hit, ack_adapter, ack_vector}, {1'b1, 19'h0});
    check("R6 nothing cleared", req_pend, 32'h1);
    @(negedge clk); vt_we = 1'b1; vt_addr = 5'd0; vt_data = 16'h1234;
    @(negedge clk); vt_we = 1'b0;
    acknowledge(3'd5);
    check("R10 rewritten vector", ack_vector, 16'h1234);
    check("R5 drained", {req_pend, lvl_mask}, 40'h0);

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule